// File: doc/BRIEF.md
# DMA Channel Request Throttle

This block turns a DMA channel's configuration into a single internal request line for the channel arbiter. Four request sources are supported. The rate-limited automatic source caps how much of the bus the channel may occupy. The full-speed automatic source requests on every cycle. The external source follows an asynchronous request pin. The mixed source issues its first request automatically and then hands control to the external pin.

In the rate-limited source, time is cut into windows of 16, 32, 64 or 128 clocks, all powers of two. A request is offered only during the leading half, quarter, eighth or sixteenth of each window. For the rest of the window it stays low. The window restarts every time the channel is started. The window and fraction settings matter only in that source.

The arbiter answers a request with a one-cycle grant. Only the mixed source looks at the grant.

Top module: `dma_req_throttle`

## Requirements
- R1: While `rst` is high, and on every cycle after reset in which `chan_en` has stayed low, `req_out` is 0.
- R2: With `req_mode` = 2'b01 (full-speed automatic), `req_out` is 1 after every clock edge at which `chan_en` is 1.
- R3: With `req_mode` = 2'b10 (external), `req_out` after edge k equals `chan_en` at edge k ANDed with the value `ext_req` had before edge k-2. This gives two synchronizer stages plus the output register.
- R4: With `req_mode` = 2'b11 (mixed), `req_out` is 1 from start until a cycle in which `grant` is 1. From the next edge on it follows the external source as in R3. The switch lasts until `chan_en` is dropped and raised again.
- R5: With `req_mode` = 2'b00 (rate-limited), the window length is 16 << `win_sel` clocks: 16, 32, 64 and 128 for codes 0 to 3.
- R6: In rate-limited mode, `req_out` is 1 for the first (window length >> (`occ_sel`+1)) enabled edges of each window and 0 for the rest. Code 0 gives 1/2, code 1 gives 1/4, code 2 gives 1/8 and code 3 gives 1/16.
- R7: The window count starts from zero at each rise of `chan_en`, so the first edge after a start falls at the beginning of a window.
- R8: `req_out` is 0 after any edge at which `chan_en` is 0, in every mode.
- R9: `win_sel` and `occ_sel` have no effect on `req_out` in modes 01, 10 and 11.
- R10: `grant` has no effect outside mode 11. A grant seen in another mode does not pre-switch a later mixed-mode request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DMA clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel active; a rise starts the channel |
| req_mode | input | 2 | Request source select (00 rate, 01 full, 10 external, 11 mixed) |
| win_sel | input | 2 | Window length select |
| occ_sel | input | 2 | Occupancy fraction select |
| ext_req | input | 1 | Asynchronous external request pin |
| grant | input | 1 | One-cycle grant from the arbiter |
| req_out | output | 1 | Registered request to the arbiter |

## Verification
The assertions assume that `req_mode`, `win_sel` and `occ_sel` stay stable while the channel runs in rate-limited mode. Without that, the window count could exceed a newly shortened window. The stimulus therefore changes these settings only while `chan_en` is low, or in modes that ignore them. The assertions also treat `ext_req` as already synchronized to `clk`, so the stimulus drives it only away from clock edges. `grant` is given only as single-cycle pulses, the way an arbiter would issue it.

// File: rtl/dma_thr_pkg.sv
package dma_thr_pkg;
  typedef enum logic [1:0] {
    SRC_RATE  = 2'b00,
    SRC_FULL  = 2'b01,
    SRC_EXT   = 2'b10,
    SRC_MIXED = 2'b11
  } req_src_e;
endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/thr_window.sv
module thr_window #(
  parameter int BASE_LOG2 = 4,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] win_sel,
  input  logic [SEL_W-1:0] occ_sel,
  output logic             win_open
);
  localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int CNT_W    = MAX_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   win_len;
  logic [CNT_W:0]   open_len;
  logic [SEL_W:0]   frac_shift;
  logic             at_end;

  always_comb begin
    win_len    = ({{CNT_W{1'b0}}, 1'b1}) << (BASE_LOG2 + int'(win_sel));
    frac_shift = {1'b0, occ_sel} + 1'b1;
    open_len   = win_len >> frac_shift;
    at_end     = ({1'b0, cnt_q} >= (win_len - 1'b1));
    win_open   = ({1'b0, cnt_q} < open_len);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0)); // R7
  AST_OPEN_AT_START: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q == '0) |-> win_open); // R6
endmodule

// File: rtl/dma_req_throttle.sv
module dma_req_throttle #(
  parameter int BASE_LOG2   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chan_en,
  input  logic [1:0] req_mode,
  input  logic [1:0] win_sel,
  input  logic [1:0] occ_sel,
  input  logic       ext_req,
  input  logic       grant,
  output logic       req_out
);
  import dma_thr_pkg::*;

  req_src_e src;
  logic     ext_sync;
  logic     win_open;
  logic     handed_off;
  logic     req_nxt;

  assign src = req_src_e'(req_mode);

  thr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_req),
    .q   (ext_sync)
  );

  thr_window #(.BASE_LOG2(BASE_LOG2), .SEL_W(2)) u_win (
    .clk      (clk),
    .rst      (rst),
    .run      (chan_en),
    .win_sel  (win_sel),
    .occ_sel  (occ_sel),
    .win_open (win_open)
  );

  // Mixed source: first grant hands the request over to the external pin.
  always_ff @(posedge clk) begin
    if (rst || !chan_en)                  handed_off <= 1'b0;
    else if (src == SRC_MIXED && grant)   handed_off <= 1'b1;
  end

  always_comb begin
    unique case (src)
      SRC_RATE:  req_nxt = win_open;
      SRC_FULL:  req_nxt = 1'b1;
      SRC_EXT:   req_nxt = ext_sync;
      SRC_MIXED: req_nxt = handed_off ? ext_sync : 1'b1;
      default:   req_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) req_out <= 1'b0;
    else     req_out <= chan_en && req_nxt;
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !req_out); // R8
  AST_FULL_SPEED: assert property (@(posedge clk) disable iff (rst)
    (chan_en && src == SRC_FULL) |=> req_out); // R2
  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (chan_en && src == SRC_EXT) |=> (req_out == $past(ext_sync))); // R3
  AST_MIXED_FIRST: assert property (@(posedge clk) disable iff (rst)
    (chan_en && src == SRC_MIXED && !handed_off) |=> req_out); // R4
  AST_RATE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (chan_en && src == SRC_RATE && !win_open) |=> !req_out); // R6
endmodule

// File: tb/sim_dma_req_throttle.sv
module sim_dma_req_throttle;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chan_en = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic [1:0] win_sel = 2'b00;
  logic [1:0] occ_sel = 2'b00;
  logic       ext_req = 1'b0;
  logic       grant = 1'b0;
  logic       req_out;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench-side state derived from the requirements
  bit h0 = 0, h1 = 0, h2 = 0;
  int pos = 0;
  bit handed = 0;

  always #2 clk = ~clk;  // 250 MHz

  dma_req_throttle u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .req_mode(req_mode),
    .win_sel(win_sel), .occ_sel(occ_sel), .ext_req(ext_req),
    .grant(grant), .req_out(req_out)
  );

  task automatic step(input bit en, input bit [1:0] md, input bit [1:0] ws,
                      input bit [1:0] os, input bit ex, input bit gn);
    item_t it;
    int wl;
    @(negedge clk);
    chan_en = en; req_mode = md; win_sel = ws; occ_sel = os;
    ext_req = ex; grant = gn;
    h2 = h1; h1 = h0; h0 = ex;
    wl = 16 << ws;  // R5
    if (!en) begin
      it.exp = 1'b0; it.tag = "R8";
    end else begin
      case (md)
        2'b00: begin it.exp = ((pos % wl) < (wl >> (os + 1))); it.tag = "R6"; end
        2'b01: begin it.exp = 1'b1; it.tag = "R2"; end
        2'b10: begin it.exp = h2; it.tag = "R3"; end
        default: begin it.exp = handed ? h2 : 1'b1; it.tag = "R4"; end
      endcase
    end
    sb_q.push_back(it);
    if (en) begin
      pos++;
      if (md == 2'b11 && gn) handed = 1;
    end else begin
      pos = 0;      // R7: window restarts on next start
      handed = 0;
    end
  endtask

  // monitor: sample one ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (req_out !== it.exp) begin
          n_fail++;
          $display("FAIL %s: req_out=%0b expected=%0b at %0t", it.tag, req_out, it.exp, $time);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (req_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: req_out=%0b expected=0 during reset", req_out);
    end
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) step(0, 2'b01, 0, 0, 1, 1);  // R1 idle stays low

    // R2 + R9: full speed with window and fraction settings moving
    for (int i = 0; i < 24; i++) step(1, 2'b01, 2'(i), 2'(i >> 2), i[0], i[1]);
    step(0, 2'b01, 0, 0, 0, 0);  // R8
    step(0, 2'b01, 0, 0, 0, 0);

    // R3 + R9: external pin pattern
    for (int i = 0; i < 40; i++) step(1, 2'b10, 2'(i), 2'(i + 1), ((i % 5) < 2), 1'b0);
    for (int i = 0; i < 3; i++) step(0, 2'b10, 0, 0, 0, 0);

    // R5 R6 R7: every window length with every fraction
    for (int w = 0; w < 4; w++) begin
      for (int o = 0; o < 4; o++) begin
        for (int i = 0; i < 2 * (16 << w) + 3; i++) step(1, 2'b00, 2'(w), 2'(o), 1'b0, 1'b0);
        step(0, 2'b00, 2'(w), 2'(o), 0, 0);  // R8, R7 restart
      end
    end

    // R8: drop enable while the window is open, then restart (R7)
    for (int i = 0; i < 3; i++) step(1, 2'b00, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 2'b00, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0);

    // R4: mixed mode, automatic first, then external after a grant
    for (int i = 0; i < 5; i++) step(1, 2'b11, 3, 3, 1'b0, 1'b0);
    step(1, 2'b11, 3, 3, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1, 2'b11, 2'(i), 0, i[1], 1'b0);
    step(0, 2'b11, 0, 0, 0, 0);
    // R4: restart clears the hand-off
    for (int i = 0; i < 6; i++) step(1, 2'b11, 0, 0, 1'b0, 1'b0);
    step(0, 2'b11, 0, 0, 0, 0);

    // R10: grant in external mode must not pre-switch mixed mode
    for (int i = 0; i < 4; i++) step(1, 2'b10, 0, 0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) step(1, 2'b11, 0, 0, 1'b0, 1'b0);
    // R10: grant in full-speed and rate modes has no effect on req_out
    step(0, 2'b01, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 2'b01, 0, 0, 0, i[0]);
    step(0, 2'b00, 0, 1, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 2'b00, 0, 1, 0, 1'b1);
    step(0, 2'b00, 0, 0, 0, 0);

    repeat (4) @(posedge clk);
    #2;
    finish_run();
  end
endmodule